// File: doc/BRIEF.md
# Presence-Tagged Shared Register File for Four Clusters

This block is the register storage that four independently sequenced execution clusters use to exchange values. Each cluster owns one bank. Every entry of a bank carries a presence flag that is either FULL or EMPTY. The lower part of a bank is private: only the owning cluster may write it. The upper part is public: any cluster may deposit a value there, but only the owner reads it. A consumer that reads an EMPTY entry is held by a stall signal until some producer fills that entry. A separate per-cluster command returns an entry to EMPTY, so the same entry can serve for the next hand-off.

Each cluster has one read port into its own bank, one write port that may target any bank, and one port that marks entries EMPTY. Writes that collide on one entry in the same cycle are settled by fixed priority. Writes that lose are told to retry, and the writer holds its request until it wins. A stalled read that meets a write to the same entry in the same cycle takes the new value and is released at once.

Top module: `rfp_cluster_rf`

## Requirements
- R1: While reset is high and in the cycle after it, every `rd_valid` bit and every `rd_data` word is zero. Reset leaves every entry EMPTY, so the first read of any entry stalls.
- R2: A read (`rd_en` high) of an EMPTY entry that no write fills in the same cycle raises that cluster's `rd_stall` in the same cycle, and `rd_valid` is low in the next cycle.
- R3: A read that does not stall raises `rd_valid` in the next cycle, and `rd_data` then carries the entry's value.
- R4: Local index values below `NPRIV` (8 by default) are private. A write to a private entry from a cluster other than its owner is dropped: the entry keeps its presence state and data, and the write asserts no retry.
- R5: Local index values from `NPRIV` to `NLOC-1` (8 to 15 by default) are public. A write from any cluster fills the entry and sets it FULL.
- R6: A write to an entry that is already FULL replaces its data, and the entry stays FULL.
- R7: A mark command (`mk_en` with `mk_idx`) on a cluster sets that cluster's own entry EMPTY from the next cycle on. If a write to the same entry lands in the same cycle, the write wins and the entry is FULL with the new data.
- R8: If several permitted writes target the same entry in one cycle, the lowest-numbered cluster wins. Every other cluster in that group sees `wr_retry` high in that cycle and its write has no effect. Writes to different entries never retry, and cluster 0 never retries.
- R9: A read and a winning write to the same entry in the same cycle give no stall. The read returns the written data in the next cycle.
- R10: A write addresses the entry at local index `wr_idx` in the bank of cluster `wr_owner`. A read and a mark always address the issuing cluster's own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | NCL | Per-cluster read request, held while stalled |
| rd_idx | input | NCL x LW | Per-cluster local index into its own bank |
| rd_stall | output | NCL | Read targets an EMPTY entry, same-cycle |
| rd_valid | output | NCL | Read data valid, one cycle after an accepted read |
| rd_data | output | NCL x DW | Read data per cluster |
| wr_en | input | NCL | Per-cluster write request |
| wr_owner | input | NCL x CW | Bank (owning cluster) the write targets |
| wr_idx | input | NCL x LW | Local index within the target bank |
| wr_data | input | NCL x DW | Write data |
| wr_retry | output | NCL | Write lost arbitration this cycle; hold and retry |
| mk_en | input | NCL | Per-cluster mark-EMPTY command |
| mk_idx | input | NCL x LW | Local index in the issuing cluster's bank to mark EMPTY |

## Verification
The bench targets private writes from a foreign cluster. A design that checks permission wrongly would fill the entry, and the next read by the owner would return data instead of stalling. It drives three clusters onto one public entry in a single cycle and checks both the retry pattern and the surviving value. A reversed or missing priority shows up as the wrong winner or a stray retry. It also pairs a denied write with a legal one to the same entry, where a design that lets illegal writers take part in arbitration would retry the legal writer. Finally, it lines up a write with a stalled read and with a mark on the same entry. A design without forwarding would hold the stall one cycle too long, and one that orders the mark after the write would leave the entry EMPTY.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  // Presence state of one register entry.
  typedef enum logic {
    PB_EMPTY = 1'b0,
    PB_FULL  = 1'b1
  } pres_e;
endpackage

// File: rtl/rfp_wr_arb.sv
// Write permission check and fixed-priority collision resolution
// across all cluster write ports.
module rfp_wr_arb #(
  parameter int NCL   = 4,
  parameter int NLOC  = 16,
  parameter int NPRIV = 8,
  localparam int LW   = $clog2(NLOC),
  localparam int CW   = $clog2(NCL)
) (
  input  logic [NCL-1:0]         wr_en_i,
  input  logic [NCL-1:0][CW-1:0] wr_owner_i,
  input  logic [NCL-1:0][LW-1:0] wr_idx_i,
  output logic [NCL-1:0]         grant_o,
  output logic [NCL-1:0]         retry_o
);
  logic [NCL-1:0] legal;

  // A write is legal when it targets a public entry or its own bank.
  always_comb begin
    for (int w = 0; w < NCL; w++) begin
      legal[w] = wr_en_i[w] &&
                 ((wr_idx_i[w] >= LW'(NPRIV)) || (wr_owner_i[w] == CW'(w)));
    end
  end

  // A legal write is blocked by any lower-numbered legal write to the same entry.
  always_comb begin
    for (int w = 0; w < NCL; w++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < w; j++) begin
        if (legal[j] && (wr_owner_i[j] == wr_owner_i[w]) &&
            (wr_idx_i[j] == wr_idx_i[w])) begin
          blocked = 1'b1;
        end
      end
      grant_o[w] = legal[w] && !blocked;
      retry_o[w] = legal[w] && blocked;
    end
  end
endmodule

// File: rtl/rfp_bank.sv
// One cluster's bank: presence flags, data words, read port with
// same-cycle write forwarding, and mark-EMPTY port.
module rfp_bank
  import rfp_pkg::*;
#(
  parameter int NCL     = 4,
  parameter int NLOC    = 16,
  parameter int DW      = 64,
  parameter int BANK_ID = 0,
  localparam int LW     = $clog2(NLOC),
  localparam int CW     = $clog2(NCL)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCL-1:0]         grant_i,
  input  logic [NCL-1:0][CW-1:0] wr_owner_i,
  input  logic [NCL-1:0][LW-1:0] wr_idx_i,
  input  logic [NCL-1:0][DW-1:0] wr_data_i,
  input  logic                   rd_en_i,
  input  logic [LW-1:0]          rd_idx_i,
  output logic                   rd_stall_o,
  output logic                   rd_valid_o,
  output logic [DW-1:0]          rd_data_o,
  input  logic                   mk_en_i,
  input  logic [LW-1:0]          mk_idx_i
);
  logic [DW-1:0]  mem_q  [NLOC];
  pres_e          pres_q [NLOC];
  logic [NCL-1:0] sel;
  logic           fwd_hit;
  logic [DW-1:0]  fwd_data;
  logic           stall_c;
  logic           take_c;

  // Writes granted into this bank, and the one (if any) matching the read.
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int w = 0; w < NCL; w++) begin
      sel[w] = grant_i[w] && (wr_owner_i[w] == CW'(BANK_ID));
      if (sel[w] && (wr_idx_i[w] == rd_idx_i)) begin
        fwd_hit  = 1'b1;
        fwd_data = wr_data_i[w];
      end
    end
    stall_c = rd_en_i && (pres_q[rd_idx_i] == PB_EMPTY) && !fwd_hit;
    take_c  = rd_en_i && !stall_c;
  end

  assign rd_stall_o = stall_c;

  // Storage update: mark first, then writes, so a same-cycle write wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLOC; i++) begin
        mem_q[i]  <= '0;
        pres_q[i] <= PB_EMPTY;
      end
    end else begin
      if (mk_en_i) begin
        pres_q[mk_idx_i] <= PB_EMPTY;
      end
      for (int w = 0; w < NCL; w++) begin
        if (sel[w]) begin
          mem_q[wr_idx_i[w]]  <= wr_data_i[w];
          pres_q[wr_idx_i[w]] <= PB_FULL;
        end
      end
    end
  end

  // Registered read result.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= take_c;
      if (take_c) begin
        rd_data_o <= fwd_hit ? fwd_data : mem_q[rd_idx_i];
      end
    end
  end
endmodule

// File: rtl/rfp_cluster_rf.sv
// Shared presence-tagged register file for NCL clusters.
module rfp_cluster_rf #(
  parameter int NCL   = 4,
  parameter int NPRIV = 8,
  parameter int NPUB  = 8,
  parameter int DW    = 64,
  localparam int NLOC = NPRIV + NPUB,
  localparam int LW   = $clog2(NLOC),
  localparam int CW   = $clog2(NCL)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCL-1:0]         rd_en,
  input  logic [NCL-1:0][LW-1:0] rd_idx,
  output logic [NCL-1:0]         rd_stall,
  output logic [NCL-1:0]         rd_valid,
  output logic [NCL-1:0][DW-1:0] rd_data,
  input  logic [NCL-1:0]         wr_en,
  input  logic [NCL-1:0][CW-1:0] wr_owner,
  input  logic [NCL-1:0][LW-1:0] wr_idx,
  input  logic [NCL-1:0][DW-1:0] wr_data,
  output logic [NCL-1:0]         wr_retry,
  input  logic [NCL-1:0]         mk_en,
  input  logic [NCL-1:0][LW-1:0] mk_idx
);
  logic [NCL-1:0] grant;

  rfp_wr_arb #(
    .NCL  (NCL),
    .NLOC (NLOC),
    .NPRIV(NPRIV)
  ) arb_i (
    .wr_en_i   (wr_en),
    .wr_owner_i(wr_owner),
    .wr_idx_i  (wr_idx),
    .grant_o   (grant),
    .retry_o   (wr_retry)
  );

  for (genvar b = 0; b < NCL; b++) begin : g_bank
    rfp_bank #(
      .NCL    (NCL),
      .NLOC   (NLOC),
      .DW     (DW),
      .BANK_ID(b)
    ) bank_i (
      .clk       (clk),
      .rst       (rst),
      .grant_i   (grant),
      .wr_owner_i(wr_owner),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .rd_en_i   (rd_en[b]),
      .rd_idx_i  (rd_idx[b]),
      .rd_stall_o(rd_stall[b]),
      .rd_valid_o(rd_valid[b]),
      .rd_data_o (rd_data[b]),
      .mk_en_i   (mk_en[b]),
      .mk_idx_i  (mk_idx[b])
    );
  end
endmodule

// File: rtl/rfp_chk.sv
module rfp_chk #(
  parameter int NCL = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCL-1:0] rd_en,
  input logic [NCL-1:0] rd_stall,
  input logic [NCL-1:0] rd_valid,
  input logic [NCL-1:0] wr_en,
  input logic [NCL-1:0] wr_retry
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (rd_valid == '0));

  // R2
  stall_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_stall & ~rd_en) == '0));

  // R8
  retry_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_retry & ~wr_en) == '0));

  // R8
  c0_never_retry_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_retry[0]);

  for (genvar g = 0; g < NCL; g++) begin : g_rd
    // R3
    accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en[g] && !rd_stall[g]) |=> rd_valid[g]);
    // R2
    stall_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd_en[g] && !rd_stall[g]) |=> !rd_valid[g]);
  end
endmodule

bind rfp_cluster_rf rfp_chk #(.NCL(NCL)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .rd_stall(rd_stall),
  .rd_valid(rd_valid),
  .wr_en   (wr_en),
  .wr_retry(wr_retry)
);

// File: tb/rfp_cluster_rf_tb_top.sv
`timescale 1ns/1ps
module rfp_cluster_rf_tb_top;
  localparam int NCL = 4;
  localparam int LW  = 4;
  localparam int CW  = 2;
  localparam int DW  = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NCL-1:0]         rd_en;
  logic [NCL-1:0][LW-1:0] rd_idx;
  logic [NCL-1:0]         rd_stall, rd_valid;
  logic [NCL-1:0][DW-1:0] rd_data;
  logic [NCL-1:0]         wr_en;
  logic [NCL-1:0][CW-1:0] wr_owner;
  logic [NCL-1:0][LW-1:0] wr_idx;
  logic [NCL-1:0][DW-1:0] wr_data;
  logic [NCL-1:0]         wr_retry;
  logic [NCL-1:0]         mk_en;
  logic [NCL-1:0][LW-1:0] mk_idx;

  rfp_cluster_rf dut_i (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_stall(rd_stall),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_owner(wr_owner), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_retry(wr_retry),
    .mk_en(mk_en), .mk_idx(mk_idx)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [1:0]  wcl;
    logic [1:0]  own;
    logic [3:0]  idx;
    logic [15:0] dat;
    logic        fills;
  } vec_t;

  // Writer, target bank, index, data pattern, whether the write takes effect.
  localparam vec_t VECS [8] = '{
    '{2'd0, 2'd0, 4'd2,  16'h1111, 1'b1},   // R4 owner private
    '{2'd1, 2'd0, 4'd2,  16'h2222, 1'b0},   // R4 foreign private dropped
    '{2'd2, 2'd0, 4'd9,  16'h3333, 1'b1},   // R5 foreign public
    '{2'd3, 2'd1, 4'd15, 16'h4444, 1'b1},   // R5 top public entry
    '{2'd0, 2'd3, 4'd7,  16'h5555, 1'b0},   // R4 last private entry
    '{2'd3, 2'd3, 4'd7,  16'h6666, 1'b1},   // R4 owner private
    '{2'd1, 2'd2, 4'd8,  16'h7777, 1'b1},   // R5 first public entry
    '{2'd2, 2'd1, 4'd0,  16'h8888, 1'b0}    // R4 foreign private dropped
  };

  function automatic logic [DW-1:0] pat(input logic [15:0] d);
    return {d, ~d, d, ~d};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    rd_en = '0; rd_idx = '0; wr_en = '0; wr_owner = '0;
    wr_idx = '0; wr_data = '0; mk_en = '0; mk_idx = '0;
  endtask

  task automatic do_mark(input int c, input int idx);
    mk_en[c] = 1'b1; mk_idx[c] = LW'(idx);
    step();
    idle();
  endtask

  task automatic do_write(input int w, input int own, input int idx,
                          input logic [DW-1:0] d);
    wr_en[w] = 1'b1; wr_owner[w] = CW'(own); wr_idx[w] = LW'(idx); wr_data[w] = d;
    step();
    idle();
  endtask

  task automatic rd_chk(input int c, input int idx, input bit exp_stall,
                        input logic [DW-1:0] exp, input string tag);
    rd_en[c] = 1'b1; rd_idx[c] = LW'(idx);
    #1;
    chk(rd_stall[c] == exp_stall, {tag, " stall"}, DW'(rd_stall[c]), DW'(exp_stall));
    step();
    chk(rd_valid[c] == !exp_stall, {tag, " valid"}, DW'(rd_valid[c]), DW'(!exp_stall));
    if (!exp_stall) chk(rd_data[c] == exp, {tag, " data"}, rd_data[c], exp);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    chk(rd_valid == '0, "R1 valid in reset", DW'(rd_valid), '0);
    chk(rd_data == '0, "R1 data in reset", rd_data[0], '0);
    rst = 1'b0;
    step();
    chk(rd_valid == '0, "R1 valid after reset", DW'(rd_valid), '0);
    // R1: every entry EMPTY after reset, R2 stall on empty
    rd_chk(0, 0, 1'b1, '0, "R1 R2 c0 empty");
    rd_chk(3, 15, 1'b1, '0, "R1 R2 c3 empty");

    // Table walk: R4 R5 R10
    foreach (VECS[i]) begin
      do_mark(int'(VECS[i].own), int'(VECS[i].idx));
      do_write(int'(VECS[i].wcl), int'(VECS[i].own), int'(VECS[i].idx),
               pat(VECS[i].dat));
      rd_chk(int'(VECS[i].own), int'(VECS[i].idx), !VECS[i].fills,
             pat(VECS[i].dat), "R4 R5 R10 vector");
    end

    // R6: overwrite a FULL entry, R3 read of a FULL entry
    do_write(0, 0, 3, pat(16'hAAAA));
    do_write(0, 0, 3, pat(16'hBBBB));
    rd_chk(0, 3, 1'b0, pat(16'hBBBB), "R6 R3 overwrite");

    // R7: mark then read stalls
    do_mark(0, 3);
    rd_chk(0, 3, 1'b1, '0, "R7 mark empties");

    // R7: mark and write in the same cycle -> FULL with new data
    do_write(1, 1, 4, pat(16'hC0C0));
    mk_en[1] = 1'b1; mk_idx[1] = 4'd4;
    wr_en[1] = 1'b1; wr_owner[1] = 2'd1; wr_idx[1] = 4'd4; wr_data[1] = pat(16'hC1C1);
    step();
    idle();
    rd_chk(1, 4, 1'b0, pat(16'hC1C1), "R7 write beats mark");

    // R8: three writers collide on bank 2 entry 10
    for (int w = 1; w < 4; w++) begin
      wr_en[w] = 1'b1; wr_owner[w] = 2'd2; wr_idx[w] = 4'd10;
      wr_data[w] = pat(16'hD000 + 16'(w));
    end
    #1;
    chk(wr_retry == 4'b1100, "R8 collision retry", DW'(wr_retry), DW'(4'b1100));
    step();
    idle();
    rd_chk(2, 10, 1'b0, pat(16'hD001), "R8 lowest wins");

    // R8: different entries in one bank, no retry
    wr_en[0] = 1'b1; wr_owner[0] = 2'd3; wr_idx[0] = 4'd8;  wr_data[0] = pat(16'hE008);
    wr_en[1] = 1'b1; wr_owner[1] = 2'd3; wr_idx[1] = 4'd9;  wr_data[1] = pat(16'hE009);
    #1;
    chk(wr_retry == '0, "R8 distinct no retry", DW'(wr_retry), '0);
    step();
    idle();
    rd_chk(3, 8, 1'b0, pat(16'hE008), "R8 distinct a");
    rd_chk(3, 9, 1'b0, pat(16'hE009), "R8 distinct b");

    // R8 R4: denied writer does not block the owner
    wr_en[0] = 1'b1; wr_owner[0] = 2'd1; wr_idx[0] = 4'd0; wr_data[0] = pat(16'hF0F0);
    wr_en[1] = 1'b1; wr_owner[1] = 2'd1; wr_idx[1] = 4'd0; wr_data[1] = pat(16'hF1F1);
    #1;
    chk(wr_retry == '0, "R8 R4 denied no block", DW'(wr_retry), '0);
    step();
    idle();
    rd_chk(1, 0, 1'b0, pat(16'hF1F1), "R8 R4 owner data");

    // R9: stalled read released by same-cycle write
    do_mark(2, 12);
    rd_en[2] = 1'b1; rd_idx[2] = 4'd12;
    #1;
    chk(rd_stall[2] == 1'b1, "R9 pre stall", DW'(rd_stall[2]), 64'd1);
    step();
    chk(rd_valid[2] == 1'b0, "R9 pre valid", DW'(rd_valid[2]), '0);
    wr_en[0] = 1'b1; wr_owner[0] = 2'd2; wr_idx[0] = 4'd12; wr_data[0] = pat(16'h9A9A);
    #1;
    chk(rd_stall[2] == 1'b0, "R9 release", DW'(rd_stall[2]), '0);
    step();
    chk(rd_valid[2] == 1'b1, "R9 valid", DW'(rd_valid[2]), 64'd1);
    chk(rd_data[2] == pat(16'h9A9A), "R9 data", rd_data[2], pat(16'h9A9A));
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule